// File: doc/BRIEF.md
# Rotate and Mask Bitfield Unit

This block is a 32-bit bitfield datapath for an integer execution pipeline. It turns two bit positions, a field start and a field stop, into a contiguous run of ones that may wrap past the end of the word. It also rotates a source word left by a 5-bit count. A 3-bit operation code then picks what the block returns: the bare mask, the rotated word cleared outside the mask, the rotated word merged into a destination word under the mask, the source merged under a mask taken from a register, or the source's top bit placed at a rotated position inside the destination.

Bit positions are counted from the most significant end: position 0 is the MSB (vector index 31), and position p is vector index 31-p. The result goes through one output register by default (parameter `OUT_REG`). That register is cleared by an asynchronous active-low reset. Decoding instructions, reading and writing registers, and setting flags are the job of the surrounding pipeline.

Top module: `rotmask_unit`

## Requirements
- R1: When start `fld_beg` <= stop `fld_end`, the generated mask has ones at positions `fld_beg` through `fld_end` inclusive and zeros everywhere else (position p = vector index 31-p).
- R2: When `fld_beg` equals `fld_end`+1, with the sum taken in 6 bits so that a stop of 31 gives 32, all 32 mask bits are ones.
- R3: When `fld_beg` > `fld_end`+1, mask positions `fld_end`+1 through `fld_beg`-1 are zeros and all other positions are ones.
- R4: Operation code 3'd0 returns the generated mask.
- R5: Operation code 3'd1 returns the source rotated left by `rot_amt`, ANDed with the generated mask. A rotate count of 0 leaves the source unrotated.
- R6: Operation code 3'd2 returns the destination with every bit where the generated mask is one replaced by the matching bit of the rotated source.
- R7: Operation code 3'd3 returns the destination with every bit where `sel_mask` is one replaced by the matching source bit. The generated mask plays no part.
- R8: Operation code 3'd4 returns the destination with the bit at vector index (`rot_amt`+31) mod 32 replaced by source bit 31 (the MSB rotated left by `rot_amt`). All other bits come from the destination.
- R9: Operation codes 3'd5, 3'd6 and 3'd7 return zero.
- R10: With `OUT_REG`=1, the result for a set of inputs appears on `result` one clock edge after those inputs are sampled. While reset is asserted, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code |
| src | input | 32 | Source word |
| dst | input | 32 | Destination word for the insert operations |
| sel_mask | input | 32 | Arbitrary mask used by operation 3'd3 |
| rot_amt | input | 5 | Left rotate count |
| fld_beg | input | 5 | Field start position (0 = MSB) |
| fld_end | input | 5 | Field stop position (0 = MSB) |
| result | output | 32 | Registered result |

## Verification
All logic ahead of the output register is combinational, so each result is due exactly one rising edge after its operands are applied. The driver applies operands on a falling edge and pushes the expected word for that operation. The monitor pops the entry 2 ns after the next rising edge and compares it, so only one entry is ever in flight and each comparison lines up with the register load. The reset value is read on a falling edge while reset is held. The mask sweep covers all 1024 start/stop pairs, and the random phase draws every operation code, including the reserved ones.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MASK    = 3'd0,
        OP_ROT_AND = 3'd1,
        OP_ROT_INS = 3'd2,
        OP_REG_INS = 3'd3,
        OP_BIT_INS = 3'd4
    } rm_op_e;

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);

    // One logarithmic stage per count bit; stage k rotates left by 2**k.
    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        logic [DATA_W-1:0] turned;
        assign turned = {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1 -: SH]};
        assign stage[k+1] = amt[k] ? turned : stage[k];
    end

    assign dout = stage[AMT_W];

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = $clog2(DATA_W)
) (
    input  logic [POS_W-1:0]  fld_beg,
    input  logic [POS_W-1:0]  fld_end,
    output logic [DATA_W-1:0] mask
);

    localparam int unsigned CMP_W = POS_W + 1;

    logic [CMP_W-1:0]  beg_x;
    logic [CMP_W-1:0]  end_p1;
    logic              wrap;
    logic [DATA_W-1:0] at_or_after_beg;
    logic [DATA_W-1:0] at_or_before_end;

    // The stop position plus one is kept one bit wider, so a stop of the
    // last position gives DATA_W and does not fold back to zero.
    assign beg_x  = {1'b0, fld_beg};
    assign end_p1 = {1'b0, fld_end} + CMP_W'(1);
    assign wrap   = (beg_x >= end_p1);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [CMP_W-1:0] POS = CMP_W'(DATA_W - 1 - i);
        assign at_or_after_beg[i]  = (POS >= beg_x);
        assign at_or_before_end[i] = (POS <  end_p1);
    end

    // A plain field is the overlap of both ranges. A wrapped field (which
    // includes the all-ones case beg == end+1) is their union.
    assign mask = wrap ? (at_or_after_beg | at_or_before_end)
                       : (at_or_after_beg & at_or_before_end);

endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] rotated,
    input  logic [DATA_W-1:0] gen_mask,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic [DATA_W-1:0] bit_mask,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] ins_val;
    logic [DATA_W-1:0] ins_mask;
    logic              do_ins;

    // All three insert flavours share one merge; only value and mask differ.
    always_comb begin
        ins_val  = rotated;
        ins_mask = gen_mask;
        do_ins   = 1'b0;
        unique case (op)
            OP_ROT_INS: begin
                ins_val  = rotated;
                ins_mask = gen_mask;
                do_ins   = 1'b1;
            end
            OP_REG_INS: begin
                ins_val  = src;
                ins_mask = sel_mask;
                do_ins   = 1'b1;
            end
            OP_BIT_INS: begin
                ins_val  = rotated;
                ins_mask = bit_mask;
                do_ins   = 1'b1;
            end
            default: begin
                ins_val  = rotated;
                ins_mask = gen_mask;
                do_ins   = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (do_ins) begin
            res = (ins_val & ins_mask) | (dst & ~ins_mask);
        end else begin
            unique case (op)
                OP_MASK:    res = gen_mask;
                OP_ROT_AND: res = rotated & gen_mask;
                default:    res = '0;
            endcase
        end
    end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned POS_W   = $clog2(DATA_W),
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic [POS_W-1:0]  rot_amt,
    input  logic [POS_W-1:0]  fld_beg,
    input  logic [POS_W-1:0]  fld_end,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
    } rm_state_t;

    rm_state_t         state_d;
    rm_state_t         state_q;

    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] gen_mask;
    logic [DATA_W-1:0] bit_mask;
    logic [POS_W-1:0]  msb_dest;
    logic [DATA_W-1:0] merged;

    rotmask_rotator #(
        .DATA_W (DATA_W),
        .AMT_W  (POS_W)
    ) u_rot (
        .din  (src),
        .amt  (rot_amt),
        .dout (rotated)
    );

    rotmask_maskgen #(
        .DATA_W (DATA_W),
        .POS_W  (POS_W)
    ) u_mask (
        .fld_beg (fld_beg),
        .fld_end (fld_end),
        .mask    (gen_mask)
    );

    // The MSB rotated left by n lands at index n-1 (mod width).
    assign msb_dest = rot_amt - POS_W'(1);

    for (genvar i = 0; i < DATA_W; i++) begin : g_onehot
        assign bit_mask[i] = (msb_dest == POS_W'(i));
    end

    rotmask_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .op       (op),
        .src      (src),
        .dst      (dst),
        .rotated  (rotated),
        .gen_mask (gen_mask),
        .sel_mask (sel_mask),
        .bit_mask (bit_mask),
        .res      (merged)
    );

    always_comb begin
        state_d        = state_q;
        state_d.result = merged;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= '0;
            end else begin
                state_q <= state_d;
            end
        end
    end else begin : g_flow
        assign state_q = state_d;
    end

    assign result = state_q.result;

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned POS_W   = $clog2(DATA_W),
    parameter bit          OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] src,
    input logic [DATA_W-1:0] dst,
    input logic [DATA_W-1:0] sel_mask,
    input logic [POS_W-1:0]  rot_amt,
    input logic [POS_W-1:0]  fld_beg,
    input logic [POS_W-1:0]  fld_end,
    input logic [DATA_W-1:0] result
);

    // Copies of the operands aligned with the cycle in which result shows them.
    logic [2:0]        c_op;
    logic [DATA_W-1:0] c_src;
    logic [DATA_W-1:0] c_dst;
    logic [DATA_W-1:0] c_sel;
    logic [POS_W-1:0]  c_amt;
    logic [POS_W-1:0]  c_beg;
    logic [POS_W-1:0]  c_end;
    logic              c_ok;

    if (OUT_REG) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_op  <= '0;
                c_src <= '0;
                c_dst <= '0;
                c_sel <= '0;
                c_amt <= '0;
                c_beg <= '0;
                c_end <= '0;
                c_ok  <= 1'b0;
            end else begin
                c_op  <= op;
                c_src <= src;
                c_dst <= dst;
                c_sel <= sel_mask;
                c_amt <= rot_amt;
                c_beg <= fld_beg;
                c_end <= fld_end;
                c_ok  <= 1'b1;
            end
        end
    end else begin : g_now
        assign c_op  = op;
        assign c_src = src;
        assign c_dst = dst;
        assign c_sel = sel_mask;
        assign c_amt = rot_amt;
        assign c_beg = fld_beg;
        assign c_end = fld_end;
        assign c_ok  = 1'b1;
    end

    p_mask_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd0 && c_beg <= c_end)
        |-> ($countones(result) == int'(c_end) - int'(c_beg) + 1));

    p_mask_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd0 && {1'b0, c_beg} == {1'b0, c_end} + 1'b1)
        |-> (result == '1));

    p_mask_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd0 && {1'b0, c_beg} > {1'b0, c_end} + 1'b1)
        |-> ($countones(result) == DATA_W - (int'(c_beg) - int'(c_end) - 1)));

    p_and_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd1 && c_amt == '0 && c_beg == '0 && c_end == '1)
        |-> (result == c_src));

    p_ins_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd2 && c_amt == '0 && {1'b0, c_beg} == {1'b0, c_end} + 1'b1)
        |-> (result == c_src));

    p_reg_ins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd3)
        |-> ((((result ^ c_dst) & ~c_sel) == '0) && (((result ^ c_src) & c_sel) == '0)));

    p_bit_ins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op == 3'd4)
        |-> ($countones(result ^ c_dst) <= 1));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_op >= 3'd5)
        |-> (result == '0));

endmodule

bind rotmask_unit rotmask_unit_chk #(
    .DATA_W  (DATA_W),
    .POS_W   (POS_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .src      (src),
    .dst      (dst),
    .sel_mask (sel_mask),
    .rot_amt  (rot_amt),
    .fld_beg  (fld_beg),
    .fld_end  (fld_end),
    .result   (result)
);

// File: tb/tb_rotmask_unit.sv
`timescale 1ns/1ps
module tb_rotmask_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src = '0;
    logic [31:0] dst = '0;
    logic [31:0] sel_mask = '0;
    logic [4:0]  rot_amt = '0;
    logic [4:0]  fld_beg = '0;
    logic [4:0]  fld_end = '0;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    rotmask_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .src      (src),
        .dst      (dst),
        .sel_mask (sel_mask),
        .rot_amt  (rot_amt),
        .fld_beg  (fld_beg),
        .fld_end  (fld_end),
        .result   (result)
    );

    // Reference model written from the requirements, position 0 = MSB.
    function automatic logic [31:0] ref_mask(input int b, input int e);
        logic [31:0] m;
        for (int p = 0; p < 32; p++) begin
            if (b <= e)          m[31-p] = (p >= b) && (p <= e);
            else if (b == e + 1) m[31-p] = 1'b1;
            else                 m[31-p] = !((p >= e + 1) && (p <= b - 1));
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_rotl(input logic [31:0] v, input int n);
        logic [63:0] dbl;
        dbl = {v, v} << n;
        return dbl[63:32];
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] o, input logic [31:0] s,
                                            input logic [31:0] d, input logic [31:0] sm,
                                            input int n, input int b, input int e);
        logic [31:0] m;
        logic [31:0] r;
        logic [31:0] out;
        m = ref_mask(b, e);
        r = ref_rotl(s, n);
        case (o)
            3'd0: out = m;
            3'd1: out = r & m;
            3'd2: out = (r & m) | (d & ~m);
            3'd3: out = (s & sm) | (d & ~sm);
            3'd4: begin
                out = d;
                out[(n + 31) % 32] = s[31];
            end
            default: out = '0;
        endcase
        return out;
    endfunction

    function automatic string tag_for(input logic [2:0] o, input int b, input int e);
        case (o)
            3'd0: begin
                if (b <= e)          return "R4/R1";
                else if (b == e + 1) return "R4/R2";
                else                 return "R4/R3";
            end
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [2:0] o, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] sm, input int n, input int b, input int e,
                         input string tag);
        item_t it;
        @(negedge clk);
        op       = o;
        src      = s;
        dst      = d;
        sel_mask = sm;
        rot_amt  = 5'(n);
        fld_beg  = 5'(b);
        fld_end  = 5'(e);
        it.exp   = ref_res(o, s, d, sm, n, b, e);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: each result is due at the rising edge after its inputs (R10).
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (result !== it.exp) begin
                errors++;
                $display("FAIL %s R10 latency: got %h expected %h", it.tag, result, it.exp);
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog R10: got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R10): result stays zero while reset is held.
        op = 3'd0; fld_beg = 5'd0; fld_end = 5'd31; src = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 32'h0) begin
            errors++;
            $display("FAIL R10 reset: got %h expected %h", result, 32'h0);
        end
        rst_n = 1'b1;

        // Every start/stop pair through the bare mask (R1, R2, R3, R4).
        for (int b = 0; b < 32; b++)
            for (int e = 0; e < 32; e++)
                drive(3'd0, 32'h0, 32'h0, 32'h0, 0, b, e, tag_for(3'd0, b, e));

        // Corner cases.
        drive(3'd1, 32'hDEAD_BEEF, 32'h0, 32'h0, 0, 0, 31, "R5 zero rotate full mask");
        drive(3'd1, 32'h8000_0001, 32'h0, 32'h0, 1, 0, 31, "R5 rotate by one");
        drive(3'd1, 32'h1234_5678, 32'h0, 32'h0, 31, 28, 3, "R5 wrapped field");
        drive(3'd2, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h0, 8, 8, 15, "R6 byte insert");
        drive(3'd2, 32'hCAFE_F00D, 32'h1111_1111, 32'h0, 0, 5, 4, "R6 full mask");
        drive(3'd2, 32'hFFFF_FFFF, 32'h0, 32'h0, 3, 20, 2, "R6 wrapped field");
        drive(3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'hF0F0_00FF, 7, 3, 9, "R7 register mask");
        drive(3'd3, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0, 0, 0, 31, "R7 empty mask");
        drive(3'd4, 32'h8000_0000, 32'h0, 32'h0, 0, 0, 0, "R8 no rotate");
        drive(3'd4, 32'h8000_0000, 32'h0, 32'h0, 1, 0, 0, "R8 to LSB");
        drive(3'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 17, 0, 0, "R8 clear one bit");
        drive(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 31, "R9 code 5");
        drive(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 31, "R9 code 7");

        // Random mix of every operation code.
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] o;
            int b;
            int e;
            o = 3'($urandom_range(0, 7));
            b = int'($urandom_range(0, 31));
            e = int'($urandom_range(0, 31));
            drive(o, $urandom, $urandom, $urandom, int'($urandom_range(0, 31)), b, e,
                  tag_for(o, b, e));
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule